// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a small, fully associative cache of address translations. Every slot holds a virtual page base, a physical page base and a page size. The size is written as the number of offset bits: 12 for a 4 KB page, 21 for a 2 MB page. Each slot also carries a set of opaque attribute flags and a global marker. Slots of every page size share one array. Each slot compares only the address bits above its own offset width, so one buffer holds small and large pages side by side.

A lookup is combinational. In the same cycle it reports hit or miss, the translated physical address and the flags of the matching slot. An external walker fills the buffer through a command port. The same port also accepts three commands: clear every slot, clear only the non-global slots, and remove the one page that covers a given virtual address.

Replacement keeps the least recently used slot in mind through per-slot age stamps. The stamps come from a single counter that only grows. A lookup can optionally renew the stamp of the slot it hits. The entry count is a parameter, and a count of zero stops elaboration.

Top module: `vptlb`

## Requirements
- R1: After reset every lookup misses. A lookup hits only when `lk_req` is 1 and some valid slot has stored base bits equal to the lookup address above that slot's offset width. On a miss, `lk_paddr` and `lk_flags` are zero.
- R2: On a hit, `lk_paddr` is the slot's physical base ORed with the low offset-width bits of the lookup address, and `lk_flags` are the flags stored at fill time.
- R3: Slots with offset widths of 12 and 21 coexist. A 21-bit slot translates any address inside its 2 MB range, up to the last byte, and misses at the first byte past it.
- R4: A fill (`cmd_op` = 1) writes the lowest-index invalid slot when one exists. When it does, no valid slot is displaced.
- R5: When no slot is invalid, a fill replaces the valid slot with the smallest stamp, taking the lowest index on a tie. Each fill stamps its slot with a value above every stamp handed out before it.
- R6: A hitting lookup with `lk_touch` = 1 renews the slot's stamp at the next edge, which protects it from the next replacement. With `lk_touch` = 0 the stamp is left as it was.
- R7: Clear-all (`cmd_op` = 2) invalidates every slot, global or not.
- R8: Clear-local (`cmd_op` = 3) invalidates only the slots whose global marker is 0. Global slots keep translating.
- R9: Drop-page (`cmd_op` = 4) invalidates the lowest-index slot that covers `cmd_vaddr`, without renewing any stamp, and leaves other slots intact. `cmd_op` = 0 does nothing.
- R10: When several valid slots cover one address, both lookup and drop use the lowest-index slot.
- R11: Commands take effect at the next rising clock edge. A lookup in the same cycle as a command sees the state from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_touch | input | 1 | Renew the stamp of the hit slot |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | PA_W | Translated physical address, zero on a miss |
| lk_flags | output | FLAG_W | Flags of the hit slot, zero on a miss |
| cmd_op | input | 3 | 0 none, 1 fill, 2 clear-all, 3 clear-local, 4 drop-page |
| cmd_vaddr | input | VA_W | Virtual page base for a fill, or address for a drop |
| cmd_paddr | input | PA_W | Physical page base for a fill |
| cmd_shift | input | SH_W | Offset width of the filled page |
| cmd_flags | input | FLAG_W | Flags of the filled page |
| cmd_global | input | 1 | Global marker of the filled page |

## Verification
A corrupted valid bit or stored base shows up on the very next lookup of that page, as a wrong hit or a wrong address. A bad stamp or a bad victim choice stays hidden until the buffer is full. It appears only after the following fill, when a lookup finds that the wrong page is gone. For that reason the bench fills all slots, renews some of them and then checks which pages survive each replacement. Clear and drop faults appear one cycle after the command, on a lookup of the page that should have gone or stayed.

// File: rtl/vptlb_pkg.sv
package vptlb_pkg;
  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_FILL       = 3'd1,
    OP_WIPE_ALL   = 3'd2,
    OP_WIPE_LOCAL = 3'd3,
    OP_DROP       = 3'd4
  } tlb_op_e;
endpackage

// File: rtl/vptlb_match.sv
module vptlb_match #(
  parameter int N     = 8,
  parameter int VA_W  = 32,
  parameter int SH_W  = 5,
  parameter int IDX_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [VA_W-1:0]            va,
  input  logic [N-1:0]               valid,
  input  logic [N-1:0][VA_W-1:0]     vbase,
  input  logic [N-1:0][SH_W-1:0]     shift,
  output logic                       hit,
  output logic [IDX_W-1:0]           idx
);
  logic [N-1:0] match;

  function automatic logic [VA_W-1:0] hi_mask(input logic [SH_W-1:0] sh);
    logic [VA_W-1:0] ones;
    ones = '1;
    return ones << sh;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid[i] &&
                      ((va & hi_mask(shift[i])) == (vbase[i] & hi_mask(shift[i])));
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;

  // R1: a reported match must point at a live slot
  p_hit_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> valid[idx]);
  // R10: no lower slot may also match the chosen one
  p_lowest_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/vptlb_victim.sv
module vptlb_victim #(
  parameter int N       = 8,
  parameter int STAMP_W = 64,
  parameter int IDX_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                valid,
  input  logic [N-1:0][STAMP_W-1:0]   stamp,
  output logic [IDX_W-1:0]            idx
);
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    old_idx = '0;
    for (int i = 1; i < N; i++) begin
      if (stamp[i] < stamp[old_idx]) old_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&valid;
  assign idx      = any_free ? free_idx : old_idx;

  // R4: with a free slot present the victim is never live
  p_victim_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> !valid[idx]);

  for (genvar j = 0; j < N; j++) begin : g_age_chk
    // R5: a full buffer evicts no slot younger than any other
    p_victim_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (&valid) |-> (stamp[idx] <= stamp[j]));
  end
endmodule

// File: rtl/vptlb_seq.sv
module vptlb_seq #(
  parameter int STAMP_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch,
  input  logic               fill,
  output logic [STAMP_W-1:0] stamp_touch,
  output logic [STAMP_W-1:0] stamp_fill
);
  logic [STAMP_W-1:0] seq_q;
  logic [STAMP_W-1:0] seq_d;
  logic               seq_en;

  assign stamp_touch = seq_q + STAMP_W'(1);
  assign stamp_fill  = seq_q + (touch ? STAMP_W'(2) : STAMP_W'(1));
  assign seq_en      = touch | fill;

  always_comb begin
    seq_d = seq_q;
    if (seq_en) seq_d = seq_q + STAMP_W'(touch) + STAMP_W'(fill);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seq_q <= '0;
    else if (seq_en) seq_q <= seq_d;
  end

  // R5: every stamp handed out exceeds all earlier ones
  p_seq_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_en |=> (seq_q > $past(seq_q)));
endmodule

// File: rtl/vptlb.sv
module vptlb
  import vptlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int SH_W      = 5,
  parameter int FLAG_W    = 4,
  parameter int STAMP_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_touch,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [FLAG_W-1:0] lk_flags,
  input  logic [2:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_vaddr,
  input  logic [PA_W-1:0]   cmd_paddr,
  input  logic [SH_W-1:0]   cmd_shift,
  input  logic [FLAG_W-1:0] cmd_flags,
  input  logic              cmd_global
);
  localparam int N     = (N_ENTRIES > 0) ? N_ENTRIES : 1;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  if (N_ENTRIES < 1) begin : g_bad_size
    $error("vptlb: N_ENTRIES must be at least 1");
  end

  tlb_op_e op;
  assign op = tlb_op_e'(cmd_op);

  logic [N-1:0]                valid_q, valid_d;
  logic [N-1:0]                glob_q;
  logic [N-1:0][VA_W-1:0]      vbase_q;
  logic [N-1:0][PA_W-1:0]      pbase_q;
  logic [N-1:0][SH_W-1:0]      shift_q;
  logic [N-1:0][FLAG_W-1:0]    flags_q;
  logic [N-1:0][STAMP_W-1:0]   stamp_q, stamp_d;

  logic             look_any, drop_any, look_hit;
  logic [IDX_W-1:0] look_idx, drop_idx, victim;
  logic             touch_fire, fill_fire, state_en;
  logic [STAMP_W-1:0] stamp_touch, stamp_fill;
  logic [VA_W-1:0]  look_lo, fill_hi;
  logic [PA_W-1:0]  fill_pbase;

  function automatic logic [VA_W-1:0] hi_of(input logic [SH_W-1:0] sh);
    logic [VA_W-1:0] ones;
    ones = '1;
    return ones << sh;
  endfunction

  vptlb_match #(.N(N), .VA_W(VA_W), .SH_W(SH_W), .IDX_W(IDX_W)) u_look (
    .clk(clk), .rst_n(rst_n), .va(lk_vaddr), .valid(valid_q),
    .vbase(vbase_q), .shift(shift_q), .hit(look_any), .idx(look_idx));

  vptlb_match #(.N(N), .VA_W(VA_W), .SH_W(SH_W), .IDX_W(IDX_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .va(cmd_vaddr), .valid(valid_q),
    .vbase(vbase_q), .shift(shift_q), .hit(drop_any), .idx(drop_idx));

  vptlb_victim #(.N(N), .STAMP_W(STAMP_W), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .stamp(stamp_q), .idx(victim));

  vptlb_seq #(.STAMP_W(STAMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .touch(touch_fire), .fill(fill_fire),
    .stamp_touch(stamp_touch), .stamp_fill(stamp_fill));

  // lookup datapath
  assign look_hit   = lk_req & look_any;
  assign look_lo    = lk_vaddr & ~hi_of(shift_q[look_idx]);
  assign lk_hit     = look_hit;
  assign lk_paddr   = look_hit ? (pbase_q[look_idx] | PA_W'(look_lo)) : '0;
  assign lk_flags   = look_hit ? flags_q[look_idx] : '0;

  // command decode
  assign touch_fire = look_hit & lk_touch;
  assign fill_fire  = (op == OP_FILL);
  assign fill_hi    = cmd_vaddr & hi_of(cmd_shift);
  assign fill_pbase = cmd_paddr & ~PA_W'(~hi_of(cmd_shift));
  assign state_en   = touch_fire | (op != OP_NONE);

  // next state for validity and age
  always_comb begin
    valid_d = valid_q;
    stamp_d = stamp_q;
    if (touch_fire) stamp_d[look_idx] = stamp_touch;
    unique case (op)
      OP_FILL: begin
        valid_d[victim] = 1'b1;
        stamp_d[victim] = stamp_fill;
      end
      OP_WIPE_ALL:   valid_d = '0;
      OP_WIPE_LOCAL: valid_d = valid_q & glob_q;
      OP_DROP: if (drop_any) valid_d[drop_idx] = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      stamp_q <= '0;
    end else if (state_en) begin
      valid_q <= valid_d;
      stamp_q <= stamp_d;
    end
  end

  // payload, written only on fill
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      vbase_q[victim] <= fill_hi;
      pbase_q[victim] <= fill_pbase;
      shift_q[victim] <= cmd_shift;
      flags_q[victim] <= cmd_flags;
      glob_q[victim]  <= cmd_global;
    end
  end

  // R4: the chosen slot is live after a fill
  p_fill_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> valid_q[$past(victim)]);
  // R7: clear-all leaves nothing live
  p_wipe_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WIPE_ALL) |=> (valid_q == '0));
  // R8: clear-local leaves only global slots
  p_wipe_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WIPE_LOCAL) |=> ((valid_q & ~glob_q) == '0));
  // R9: a drop that found its page removes it
  p_drop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DROP && drop_any) |=> !valid_q[$past(drop_idx)]);
endmodule

// File: tb/tb_vptlb.sv
`timescale 1ns/100ps
module tb_vptlb;
  localparam int N = 4, VA_W = 32, PA_W = 32, SH_W = 5, FLAG_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_req, lk_touch, lk_hit, cmd_global;
  logic [VA_W-1:0] lk_vaddr, cmd_vaddr;
  logic [PA_W-1:0] lk_paddr, cmd_paddr;
  logic [FLAG_W-1:0] lk_flags, cmd_flags;
  logic [2:0] cmd_op;
  logic [SH_W-1:0] cmd_shift;

  always #2.5 clk = ~clk;

  vptlb #(.N_ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .SH_W(SH_W), .FLAG_W(FLAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_touch(lk_touch),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_flags(lk_flags), .cmd_op(cmd_op),
    .cmd_vaddr(cmd_vaddr), .cmd_paddr(cmd_paddr), .cmd_shift(cmd_shift),
    .cmd_flags(cmd_flags), .cmd_global(cmd_global));

  typedef struct {
    logic              hit;
    logic [PA_W-1:0]   pa;
    logic [FLAG_W-1:0] fl;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic tick();
    @(negedge clk);
    lk_req = 0; lk_touch = 0; lk_vaddr = '0;
    cmd_op = 3'd0; cmd_vaddr = '0; cmd_paddr = '0; cmd_shift = '0;
    cmd_flags = '0; cmd_global = 0;
  endtask

  task automatic set_cmd(input logic [2:0] op, input logic [31:0] va, input logic [31:0] pa,
                         input logic [4:0] sh, input logic [3:0] fl, input logic gl);
    cmd_op = op; cmd_vaddr = va; cmd_paddr = pa; cmd_shift = sh;
    cmd_flags = fl; cmd_global = gl;
  endtask

  task automatic set_look(input logic req, input logic [31:0] va, input logic touch,
                          input logic eh, input logic [31:0] epa, input logic [3:0] efl,
                          input string tag);
    exp_t e;
    lk_req = req; lk_vaddr = va; lk_touch = touch;
    e.hit = eh; e.pa = epa; e.fl = efl; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // cycle with a single lookup
  task automatic look(input logic [31:0] va, input logic touch, input logic eh,
                      input logic [31:0] epa, input logic [3:0] efl, input string tag);
    tick();
    set_look(1'b1, va, touch, eh, epa, efl, tag);
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [4:0] sh,
                      input logic [3:0] fl, input logic gl);
    tick();
    set_cmd(3'd1, va, pa, sh, fl, gl);
  endtask

  // monitor: compares each queued expectation after the inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_tests++;
        if (lk_hit !== e.hit || lk_paddr !== e.pa || lk_flags !== e.fl) begin
          n_fail++;
          $display("FAIL %s: got hit=%0b pa=%h fl=%h, expected hit=%0b pa=%h fl=%h",
                   e.tag, lk_hit, lk_paddr, lk_flags, e.hit, e.pa, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    lk_req = 0; lk_touch = 0; lk_vaddr = '0;
    cmd_op = 3'd0; cmd_vaddr = '0; cmd_paddr = '0; cmd_shift = '0;
    cmd_flags = '0; cmd_global = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    look(32'h0000_1234, 0, 0, 0, 0, "R1 empty after reset");

    fill(32'h0000_5000, 32'h0008_0000, 5'd12, 4'h3, 0);   // A slot0
    fill(32'h0040_0000, 32'h1000_0000, 5'd21, 4'h5, 1);   // B slot1
    look(32'h0000_5ABC, 0, 1, 32'h0008_0ABC, 4'h3, "R2 small page translate");
    look(32'h0045_6789, 0, 1, 32'h1005_6789, 4'h5, "R3 large page translate");
    look(32'h0000_6000, 0, 0, 0, 0, "R1 neighbour page misses");
    look(32'h005F_FFFF, 0, 1, 32'h101F_FFFF, 4'h5, "R3 last byte of large page");
    look(32'h0060_0000, 0, 0, 0, 0, "R3 first byte past large page");

    // R11: lookup during the fill still sees the old state
    tick();
    set_cmd(3'd1, 32'h0000_7000, 32'h0009_0000, 5'd12, 4'h0, 0);  // C slot2
    set_look(1'b1, 32'h0000_7000, 0, 0, 0, 0, "R11 fill not visible same cycle");
    look(32'h0000_7000, 0, 1, 32'h0009_0000, 4'h0, "R11 fill visible next cycle");
    fill(32'h0000_8000, 32'h000A_0000, 5'd12, 4'h1, 0);   // D slot3, now full

    look(32'h0000_5000, 1, 1, 32'h0008_0000, 4'h3, "R6 refresh A");
    look(32'h0040_0000, 0, 1, 32'h1000_0000, 4'h5, "R6 plain look at B");
    fill(32'h0000_9000, 32'h000B_0000, 5'd12, 4'h6, 0);   // E evicts B
    look(32'h0040_0000, 0, 0, 0, 0, "R5 oldest B evicted, plain look did not renew");
    look(32'h0000_5000, 0, 1, 32'h0008_0000, 4'h3, "R6 refreshed A kept");
    look(32'h0000_9000, 0, 1, 32'h000B_0000, 4'h6, "R5 new page present");
    fill(32'h0000_A000, 32'h000C_0000, 5'd12, 4'h7, 0);   // F evicts C
    look(32'h0000_7000, 0, 0, 0, 0, "R5 next oldest C evicted");
    look(32'h0000_8000, 0, 1, 32'h000A_0000, 4'h1, "R5 younger D kept");

    tick();
    set_cmd(3'd4, 32'h0000_8123, 0, 0, 0, 0);             // drop D
    look(32'h0000_8000, 0, 0, 0, 0, "R9 dropped page misses");
    look(32'h0000_A000, 0, 1, 32'h000C_0000, 4'h7, "R9 other page intact");
    tick();                                                // no-op
    look(32'h0000_5000, 0, 1, 32'h0008_0000, 4'h3, "R9 no-op keeps A");

    fill(32'h0000_B000, 32'h000D_0000, 5'd12, 4'h9, 0);   // G into free slot3
    look(32'h0000_5000, 0, 1, 32'h0008_0000, 4'h3, "R4 free slot used, A kept");
    look(32'h0000_9000, 0, 1, 32'h000B_0000, 4'h6, "R4 free slot used, E kept");
    look(32'h0000_A000, 0, 1, 32'h000C_0000, 4'h7, "R4 free slot used, F kept");
    look(32'h0000_B000, 0, 1, 32'h000D_0000, 4'h9, "R4 new page in free slot");

    fill(32'h0000_0000, 32'h2000_0000, 5'd21, 4'h8, 1);   // H evicts A into slot0
    look(32'h0000_9010, 0, 1, 32'h2000_9010, 4'h8, "R10 lowest slot wins overlap");
    look(32'h0000_5000, 0, 1, 32'h2000_5000, 4'h8, "R5 A replaced by H");

    tick();
    set_cmd(3'd3, 0, 0, 0, 0, 0);                         // clear-local
    look(32'h0000_9010, 0, 1, 32'h2000_9010, 4'h8, "R8 global page survives");
    tick();
    set_cmd(3'd4, 32'h0000_9010, 0, 0, 0, 0);             // drop H
    look(32'h0000_9010, 0, 0, 0, 0, "R8 local pages gone after drop of global");
    look(32'h0000_B000, 0, 0, 0, 0, "R8 local page G gone");

    fill(32'h0000_C000, 32'h000E_0000, 5'd12, 4'h2, 1);   // I global
    tick();
    set_look(1'b0, 32'h0000_C000, 0, 0, 0, 0, "R1 no request no hit");
    look(32'h0000_C000, 0, 1, 32'h000E_0000, 4'h2, "R2 global page translate");
    tick();
    set_cmd(3'd2, 0, 0, 0, 0, 0);
    set_look(1'b1, 32'h0000_C000, 0, 1, 32'h000E_0000, 4'h2, "R11 clear not visible same cycle");
    look(32'h0000_C000, 0, 0, 0, 0, "R7 clear-all removes global page");

    fill(32'h0000_D000, 32'h000F_0000, 5'd12, 4'hA, 0);
    look(32'h0000_DFFF, 0, 1, 32'h000F_0FFF, 4'hA, "R4 refill after clear");

    tick();
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule